// File: doc/BRIEF.md
# Serial Boot Mode Loader

This block gathers a processor's fundamental configuration from a slow serial bit stream while the chip is in reset, then keeps that configuration as static mode outputs for the rest of the run. It divides the master clock by 256 to make a serial clock for an external serial memory or simple logic source. It shifts in a fixed 20-bit mode word, least significant bit first, and releases the word once it is complete and the reset input has gone high.

Three fields are decoded from the mode word: a system bus width select, a clock multiplier between 2 and 8, and a write-data delay of 0 to 7 master clock cycles. An illegal multiplier code is reported on an error flag. Until loading is complete every decoded output holds a safe default, so logic downstream never sees a partial word.

The controller has three states. SHIFT takes in one bit on each rising edge of the serial clock. HOLD keeps the complete word while reset is still asserted. DONE publishes the word. Transitions: SHIFT to DONE when the last bit arrives with reset already released. SHIFT to HOLD when the last bit arrives while reset is still asserted. HOLD to DONE on reset release. Any state goes to SHIFT on a new falling edge of reset or on cold reset.

Top module: `boot_mode_loader`

## Requirements
- R1: `sclk` is the master clock divided by 256. After a capture restart it is low for clocks 1 to 127 and high from clock 128 to clock 255, counting master clock edges from the restart edge as clock 0. It rises on the same edge that samples `sdi`.
- R2: The mode word is exactly 20 bits. The first bit received lands in `mode_word[0]` and the last in `mode_word[19]`. Bit k is sampled at clock 128 + 256·k after the restart edge.
- R3: `done` rises on the edge that samples bit 19 if `rst_n` is high at that edge. Otherwise it rises on the first edge at which `rst_n` is seen high. While `done` stays high, changes on `sdi` leave `mode_word` unchanged.
- R4: While `done` is low: `mode_word` is 0, `bus_is_32` is 0 (64-bit), `clk_mult` is 2, `wr_delay` is 0 and `mult_err` is 0.
- R5: When `done` is high, `bus_is_32` equals `mode_word[8]`. A value of 1 selects the 32-bit bus.
- R6: When `done` is high, the multiplier code is `mode_word[3:1]`. For codes 0 to 6, `clk_mult` equals code + 2.
- R7: A multiplier code of 7 (binary 111) sets `mult_err` to 1 and forces `clk_mult` to 2.
- R8: When `done` is high, `wr_delay` equals `mode_word[17:15]`.
- R9: A high-to-low change of `rst_n`, seen at a master clock edge, restarts the load. That edge clears the shift register, the bit count, the divider and `done`, and the next word fully replaces the old one.
- R10: `cold_rst_n` low clears all state at once, without a clock edge. After it is released, capture starts from bit 0.
- R11: Releasing `rst_n` before the 20th bit neither stops nor restarts the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| cold_rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_n | input | 1 | Active-low reset; the load runs while it is low, and a new falling edge restarts the load |
| sdi | input | 1 | Serial mode data in |
| sclk | output | 1 | Serial clock, master clock divided by 256 |
| mode_word | output | 20 | Captured mode word, 0 until done |
| bus_is_32 | output | 1 | 1 selects 32-bit system bus, 0 selects 64-bit |
| clk_mult | output | 4 | Clock multiplier value, 2 to 8 |
| wr_delay | output | 3 | Write address to data delay in master clocks |
| mult_err | output | 1 | Illegal multiplier code loaded |
| done | output | 1 | Mode word loaded and reset released |

## Verification
The hardest situation to create from the ports is the exact edge at which `done` rises, because it sits more than 4,900 master clocks after a restart. It also depends on whether `rst_n` was released before the last bit or after it. The stimulus counts master clock edges from the restart edge and changes `sdi` only in the half period after each serial sample. It checks `done` one clock before the 20th sample and again on that sample, once with reset released early and once with reset held past the end. Restarts are also forced in the middle of a word and after a completed word, to show that no old bits survive.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

    // Stream geometry
    localparam int WORD_W      = 20;
    localparam int DIV_LOG2    = 8;

    // Field positions inside the mode word
    localparam int WIDTH_BIT   = 8;
    localparam int MULT_LSB    = 1;
    localparam int MULT_W      = 3;
    localparam int DLY_LSB     = 15;
    localparam int DLY_W       = 3;

    // Multiplier encoding: value = code + MULT_BASE, codes >= MULT_BAD illegal
    localparam int MULT_BASE   = 2;
    localparam int MULT_BAD    = 7;
    localparam int MULT_OUT_W  = $clog2(MULT_BASE + (1 << MULT_W));

    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DONE  = 2'd2
    } boot_state_e;

    typedef struct packed {
        logic                  bus_is_32;
        logic [MULT_OUT_W-1:0] clk_mult;
        logic [DLY_W-1:0]      wr_delay;
        logic                  mult_err;
    } boot_fields_t;

endpackage

// File: rtl/boot_clk_div.sv
module boot_clk_div #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic cold_rst_n,
    input  logic clr,
    output logic sclk,
    output logic tick
);

    localparam logic [DIV_LOG2-1:0] HALF_M1 = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);

    logic [DIV_LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sample strobe: the edge at which the serial clock goes high
    assign tick = (cnt_q == HALF_M1);
    assign sclk = cnt_q[DIV_LOG2-1];

    AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (tick && !clr) |=> $rose(sclk)); // R1

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!cold_rst_n)
        clr |=> !sclk); // R9

endmodule

// File: rtl/boot_capture_fsm.sv
module boot_capture_fsm
    import boot_mode_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              tick,
    output logic              clr,
    output logic [WORD_W-1:0] word,
    output logic              done
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    boot_state_e       state_q;
    boot_state_e       state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [WORD_W-1:0] shift_q;
    logic              rst_seen_q;
    logic              last_bit;

    // Falling edge of rst_n restarts the load
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            rst_seen_q <= 1'b0;
        end else begin
            rst_seen_q <= rst_n;
        end
    end

    assign clr      = rst_seen_q && !rst_n;
    assign last_bit = tick && (bit_cnt_q == LAST_BIT);

    // State register
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            state_q <= ST_SHIFT;
        end else if (clr) begin
            state_q <= ST_SHIFT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: begin
                if (last_bit) begin
                    state_d = rst_n ? ST_DONE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (rst_n) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_SHIFT;
            end
        endcase
    end

    // Shift register and bit count
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            shift_q   <= '0;
            bit_cnt_q <= '0;
        end else if (clr) begin
            shift_q   <= '0;
            bit_cnt_q <= '0;
        end else if ((state_q == ST_SHIFT) && tick) begin
            shift_q   <= {sdi, shift_q[WORD_W-1:1]};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        done = 1'b0;
        word = shift_q;
        unique case (state_q)
            ST_SHIFT: done = 1'b0;
            ST_HOLD:  done = 1'b0;
            ST_DONE:  done = 1'b1;
            default:  done = 1'b0;
        endcase
    end

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!cold_rst_n)
        bit_cnt_q <= CNT_W'(WORD_W)); // R2

    AST_FROZEN_WORD: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (done && $past(done)) |-> $stable(shift_q)); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!cold_rst_n)
        clr |=> (!done && bit_cnt_q == '0)); // R9

    AST_DONE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(done) |-> $past(rst_n)); // R3

endmodule

// File: rtl/boot_mode_decode.sv
module boot_mode_decode
    import boot_mode_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output boot_fields_t      fields
);

    logic [MULT_W-1:0] code;
    logic              illegal;

    assign code    = word_in[MULT_LSB +: MULT_W];
    assign illegal = (int'(code) >= MULT_BAD);

    always_comb begin
        word_out        = '0;
        fields.bus_is_32 = 1'b0;
        fields.clk_mult  = MULT_OUT_W'(MULT_BASE);
        fields.wr_delay  = '0;
        fields.mult_err  = 1'b0;
        if (valid) begin
            word_out         = word_in;
            fields.bus_is_32 = word_in[WIDTH_BIT];
            fields.wr_delay  = word_in[DLY_LSB +: DLY_W];
            fields.mult_err  = illegal;
            if (!illegal) begin
                fields.clk_mult = MULT_OUT_W'(code) + MULT_OUT_W'(MULT_BASE);
            end
        end
    end

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
    import boot_mode_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic              sdi,
    output logic              sclk,
    output logic [WORD_W-1:0] mode_word,
    output logic              bus_is_32,
    output logic [MULT_OUT_W-1:0] clk_mult,
    output logic [DLY_W-1:0]  wr_delay,
    output logic              mult_err,
    output logic              done
);

    logic              tick;
    logic              clr;
    logic [WORD_W-1:0] raw_word;
    boot_fields_t      fields;

    boot_clk_div #(
        .DIV_LOG2 (DIV_LOG2)
    ) i_div (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .clr        (clr),
        .sclk       (sclk),
        .tick       (tick)
    );

    boot_capture_fsm #(
        .WORD_W (WORD_W)
    ) i_fsm (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .rst_n      (rst_n),
        .sdi        (sdi),
        .tick       (tick),
        .clr        (clr),
        .word       (raw_word),
        .done       (done)
    );

    boot_mode_decode i_dec (
        .valid    (done),
        .word_in  (raw_word),
        .word_out (mode_word),
        .fields   (fields)
    );

    assign bus_is_32 = fields.bus_is_32;
    assign clk_mult  = fields.clk_mult;
    assign wr_delay  = fields.wr_delay;
    assign mult_err  = fields.mult_err;

    AST_SAFE_DEFAULTS: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !done |-> (mode_word == '0 && !bus_is_32 && clk_mult == MULT_OUT_W'(MULT_BASE)
                   && wr_delay == '0 && !mult_err)); // R4

    AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        done |-> (clk_mult >= MULT_OUT_W'(2) && clk_mult <= MULT_OUT_W'(8))); // R6

    AST_ERR_ONLY_ILLEGAL: assert property (@(posedge clk) disable iff (!cold_rst_n)
        mult_err |-> (done && mode_word[3:1] == 3'b111 && clk_mult == MULT_OUT_W'(2))); // R7

    AST_WIDTH_FIELD: assert property (@(posedge clk) disable iff (!cold_rst_n)
        done |-> (bus_is_32 == mode_word[8])); // R5

    AST_DELAY_FIELD: assert property (@(posedge clk) disable iff (!cold_rst_n)
        done |-> (wr_delay == mode_word[17:15])); // R8

endmodule

// File: tb/test_boot_mode_loader.sv
module test_boot_mode_loader;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sclk;
    logic [19:0] mode_word;
    logic        bus_is_32;
    logic [3:0]  clk_mult;
    logic [2:0]  wr_delay;
    logic        mult_err;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    boot_mode_loader i_boot_mode_loader (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .rst_n      (rst_n),
        .sdi        (sdi),
        .sclk       (sclk),
        .mode_word  (mode_word),
        .bus_is_32  (bus_is_32),
        .clk_mult   (clk_mult),
        .wr_delay   (wr_delay),
        .mult_err   (mult_err),
        .done       (done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_defaults(input string req);
        check(req, "mode_word idle", int'(mode_word), 0);
        check(req, "bus_is_32 idle", int'(bus_is_32), 0);
        check(req, "clk_mult idle", int'(clk_mult), 2);
        check(req, "wr_delay idle", int'(wr_delay), 0);
        check(req, "mult_err idle", int'(mult_err), 0);
    endtask

    task automatic check_fields(input logic [19:0] bits);
        int code;
        code = int'(bits[3:1]);
        check("R2", "mode_word", int'(mode_word), int'(bits));
        check("R5", "bus_is_32", int'(bus_is_32), int'(bits[8]));
        check("R6", "clk_mult", int'(clk_mult), (code == 7) ? 2 : code + 2);
        check("R7", "mult_err", int'(mult_err), (code == 7) ? 1 : 0);
        check("R8", "wr_delay", int'(wr_delay), int'(bits[17:15]));
    endtask

    // Restart by a falling rst_n, stream 20 bits, check timing and fields
    task automatic run_capture(input logic [19:0] bits, input bit early, input bit timing);
        int e;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        e = 0;
        check("R9", "done after restart", int'(done), 0);
        while (e < 4992) begin
            sdi = bits[e / 256];
            if (early && e == 100) rst_n = 1'b1;
            @(posedge clk); #1;
            e++;
            if (timing) begin
                if (e == 127) check("R1", "sclk before half", int'(sclk), 0);
                if (e == 128) check("R1", "sclk at half", int'(sclk), 1);
                if (e == 256) check("R1", "sclk at period", int'(sclk), 0);
                if (e == 4991) begin
                    check("R3", "done one clock early", int'(done), 0);
                    check_defaults("R4");
                end
            end
        end
        check(early ? "R11" : "R3", "done at last bit", int'(done), early ? 1 : 0);
        if (!early) begin
            check_defaults("R4");
            rst_n = 1'b1;
            @(posedge clk); #1;
            check("R3", "done on release", int'(done), 1);
        end
        check_fields(bits);
    endtask

    task automatic t_reset_state;
        #5;
        check("R10", "done in cold reset", int'(done), 0);
        check_defaults("R10");
        @(negedge clk) cold_rst_n = 1'b1;
        @(posedge clk); #1;
        check_defaults("R4");
    endtask

    task automatic t_mult_sweep;
        for (int c = 0; c < 8; c++) begin
            logic [19:0] w;
            w = 20'h5A5A0 ^ (20'(c) << 1) ^ (20'(c) << 15) ^ (20'(c & 1) << 8);
            w[3:1] = 3'(c);
            run_capture(w, c[0], (c == 0));
        end
    endtask

    task automatic t_freeze;
        logic [19:0] w;
        w = 20'hB7E39;
        run_capture(w, 1'b1, 1'b0);
        for (int i = 0; i < 700; i++) begin
            sdi = ~sdi;
            @(posedge clk); #1;
        end
        check("R3", "frozen word", int'(mode_word), int'(w));
        check("R3", "done held", int'(done), 1);
    endtask

    task automatic t_restart_mid;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        sdi = 1'b1;
        repeat (3000) @(posedge clk);
        #1;
        check("R9", "done mid capture", int'(done), 0);
        run_capture(20'h0A5C3, 1'b0, 1'b0);
    endtask

    task automatic t_cold_reset;
        @(negedge clk) cold_rst_n = 1'b0;
        #2;
        check("R10", "done cleared async", int'(done), 0);
        check("R10", "mode_word cleared async", int'(mode_word), 0);
        rst_n = 1'b0;
        @(negedge clk) cold_rst_n = 1'b1;
        run_capture(20'h38102, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset_state();
        run_capture(20'hA8100, 1'b0, 1'b1);
        run_capture(20'hF800C, 1'b1, 1'b1);
        t_mult_sweep();
        t_freeze();
        t_restart_mid();
        t_cold_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3_600_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule